// File: doc/BRIEF.md
# Chain-Indexed I/O Address Translator

This block sits between DMA-capable devices and system memory and turns each 28-bit device address (IOVA) into a 52-bit physical address. Translations are cached in a direct-mapped table of 256 slots. The slot for an address is not found by searching: it is read straight out of the IOVA, from the upper bits that a programmable chain mask selects. Each slot keeps the full IOVA page number as a tag, so a slot holding a different page counts as a miss. On a miss, the block reads one 64-bit translation entry from an in-memory page directory through a read port, places it in the slot and answers the request.

Software uses a 32-bit write-only register port to set the operating mode, the chain mask and the directory base, and to stage a 64-bit entry in two halves. A single write to the command register carries both an operation code and a target address. That write either discards one slot or loads the staged entry into one slot. The translation port and the memory read request use valid/ready handshakes. After reset the block forwards addresses unchanged until software selects translation.

Back-pressure rules: `req_ready` is high only while no request is in flight, so the block handles one translation at a time. Once `rsp_valid` rises, `rsp_pa` and `rsp_err` hold their values until a cycle with `rsp_ready` high. Once `mem_req_valid` rises, it and `mem_req_addr` hold until a cycle with `mem_req_ready` high. `mem_rsp_valid` is a one-cycle strobe with no ready signal, and the block accepts it in any cycle while it waits for read data.

Top module: `iotlb_xlate`

## Requirements
- R1: Reset selects pass-through mode, marks every slot empty, clears the directory base and sets the chain mask to 0x0FF00000. While reset is low, no response and no memory request is pending and `req_ready` is high.
- R2: Pass-through applies when the mode field (control bits 17:16) is 0, or when include bits 8:7 are both zero and the mode is not 1. The response then carries the IOVA zero-extended to 52 bits, `rsp_err`=0, and the block issues no memory read.
- R3: In translate mode (control 0x20080: mode field 2, include bit 7 set), a miss issues exactly one memory read at address {base[31:3],3'b000} + (IOVA[27:12] × 8).
- R4: A directory entry with bit 0 set gives the physical address {entry[63:60], entry[47:12], IOVA[11:0]}. The entry is stored, so a later request to the same page is answered with no memory read.
- R5: If a fetched entry has bit 0 clear, the response has `rsp_err`=1 and `rsp_pa`=0, and the slot is left unchanged, so a repeated request fetches again. Every error response carries `rsp_pa`=0.
- R6: The slot index is ((IOVA & chain mask) >> 20)[7:0]. A slot hits only when it is occupied, its tag equals IOVA[27:12] and its stored entry has bit 0 set. A fill replaces whatever the slot held.
- R7: A command write (select 1) whose low byte is 35 copies the staged entry into the slot taken from the written word. The upper half comes from select 4 and the lower half from select 5. The slot takes its tag from word bits 27:12.
- R8: A command write whose low byte is 33 empties the slot taken from the written word. Purging an already empty slot changes nothing.
- R9: Mode field 1 (for example control 0x10080) answers every request with `rsp_err`=1 and issues no memory read.
- R10: The handshakes follow the back-pressure rules above. The block holds at most one request at a time.
- R11: Command writes with any other low-byte code, and writes to selects 6 and 7, have no effect on translation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 3 | Register select: 0 control, 1 command, 2 chain mask, 3 directory base, 4 staged upper half, 5 staged lower half |
| cfg_wdata | input | 32 | Register write data |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Block can accept a request |
| req_iova | input | 28 | Device address to translate |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Consumer accepts the response |
| rsp_pa | output | 52 | Physical address (0 on error) |
| rsp_err | output | 1 | Translation failed |
| mem_req_valid | output | 1 | Directory read request valid |
| mem_req_ready | input | 1 | Memory accepts the read request |
| mem_req_addr | output | 32 | Byte address of the 64-bit directory entry |
| mem_rsp_valid | input | 1 | Read data strobe |
| mem_rsp_data | input | 64 | Directory entry read back |

## Verification
On every cycle, the assertions check the handshake rules: a stalled response and a stalled memory request stay stable, no request is accepted while one is in flight, at most one directory read happens per translation, and error responses carry a zero address. Only the bench scenarios can show whether the translated addresses are right. This covers pass-through versus translate versus error mode, hits after fills, the absence of fills from invalid entries, slot conflicts under the default and a narrowed chain mask, the direct-write and purge commands, and the emptying of the table by reset. The bench shows these by counting memory reads and comparing response values against its own model.

// File: rtl/iotlb_pkg.sv
package iotlb_pkg;
  localparam int CFG_W      = 32;
  localparam int ENT_W      = 64;
  localparam int PG_SHIFT   = 12;
  localparam int PPN_LO_MSB = 47;
  localparam int PPN_HI_LSB = 60;
  localparam int PPN_W      = (ENT_W - PPN_HI_LSB) + (PPN_LO_MSB - PG_SHIFT + 1);
  localparam int PA_W       = PPN_W + PG_SHIFT;
  localparam int E_VALID    = 0;

  localparam logic [7:0] CMD_PURGE  = 8'd33;
  localparam logic [7:0] CMD_DWRITE = 8'd35;

  typedef enum logic [1:0] {
    TM_REAL   = 2'd0,
    TM_ERROR  = 2'd1,
    TM_NORMAL = 2'd2,
    TM_RSVD   = 2'd3
  } tlb_mode_e;

  typedef enum logic [2:0] {
    RS_CTRL   = 3'd0,
    RS_CMD    = 3'd1,
    RS_MASK   = 3'd2,
    RS_BASE   = 3'd3,
    RS_STG_HI = 3'd4,
    RS_STG_LO = 3'd5
  } reg_sel_e;

  typedef enum logic [2:0] {
    W_IDLE,
    W_LOOK,
    W_FREQ,
    W_FWAIT,
    W_RESP
  } walk_st_e;

  // Physical address = high page bits, low page bits, page offset
  function automatic logic [PA_W-1:0] entry_to_pa(input logic [ENT_W-1:0] e,
                                                  input logic [PG_SHIFT-1:0] off);
    return {e[ENT_W-1:PPN_HI_LSB], e[PPN_LO_MSB:PG_SHIFT], off};
  endfunction
endpackage

// File: rtl/iotlb_cfg_regs.sv
module iotlb_cfg_regs
  import iotlb_pkg::*;
#(
  parameter int IOVA_W  = 28,
  parameter int CHAIN_W = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_en,
  input  logic [2:0]                    wr_sel,
  input  logic [CFG_W-1:0]              wr_data,
  output tlb_mode_e                     mode,
  output logic                          incl_on,
  output logic [CFG_W-1:0]              chain_mask,
  output logic [CFG_W-1:0]              pdir_base,
  output logic [ENT_W-1:0]              stage_entry,
  output logic                          purge_en,
  output logic                          dwrite_en,
  output logic [CHAIN_W-1:0]            cmd_slot,
  output logic [IOVA_W-PG_SHIFT-1:0]    cmd_tag
);
  localparam int CHAIN_SHIFT = IOVA_W - CHAIN_W;
  localparam logic [CFG_W-1:0] MASK_RST =
    CFG_W'(((64'd1 << CHAIN_W) - 64'd1) << CHAIN_SHIFT);

  tlb_mode_e        mode_q;
  logic [1:0]       incl_q;
  logic [CFG_W-1:0] mask_q;
  logic [CFG_W-1:0] base_q;
  logic [CFG_W-1:0] stg_hi_q;
  logic [CFG_W-1:0] stg_lo_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q   <= TM_REAL;
      incl_q   <= 2'b00;
      mask_q   <= MASK_RST;
      base_q   <= '0;
      stg_hi_q <= '0;
      stg_lo_q <= '0;
    end else if (wr_en) begin
      case (wr_sel)
        RS_CTRL: begin
          mode_q <= tlb_mode_e'(wr_data[17:16]);
          incl_q <= wr_data[8:7];
        end
        RS_MASK:   mask_q   <= wr_data;
        RS_BASE:   base_q   <= wr_data;
        RS_STG_HI: stg_hi_q <= wr_data;
        RS_STG_LO: stg_lo_q <= wr_data;
        default: ;
      endcase
    end
  end

  // Command word decode: code in the low byte, target in the address bits
  logic [CFG_W-1:0] cmd_masked;
  logic             cmd_hit;
  logic             unused_cmd_bits;

  assign cmd_masked      = wr_data & mask_q;
  assign cmd_hit         = wr_en && (wr_sel == RS_CMD);
  assign purge_en        = cmd_hit && (wr_data[7:0] == CMD_PURGE);
  assign dwrite_en       = cmd_hit && (wr_data[7:0] == CMD_DWRITE);
  assign cmd_slot        = cmd_masked[CHAIN_SHIFT +: CHAIN_W];
  assign cmd_tag         = wr_data[IOVA_W-1:PG_SHIFT];
  assign unused_cmd_bits = ^{cmd_masked[CFG_W-1:IOVA_W], cmd_masked[CHAIN_SHIFT-1:0]};

  assign mode        = mode_q;
  assign incl_on     = |incl_q;
  assign chain_mask  = mask_q;
  assign pdir_base   = base_q;
  assign stage_entry = {stg_hi_q, stg_lo_q};
endmodule

// File: rtl/iotlb_entry_array.sv
module iotlb_entry_array
  import iotlb_pkg::*;
#(
  parameter int CHAIN_W = 8,
  parameter int TAG_W   = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [CHAIN_W-1:0] rd_slot,
  output logic               rd_live,
  output logic [TAG_W-1:0]   rd_tag,
  output logic [ENT_W-1:0]   rd_entry,
  input  logic               fill_en,
  input  logic [CHAIN_W-1:0] fill_slot,
  input  logic [TAG_W-1:0]   fill_tag,
  input  logic [ENT_W-1:0]   fill_entry,
  input  logic               dw_en,
  input  logic [CHAIN_W-1:0] dw_slot,
  input  logic [TAG_W-1:0]   dw_tag,
  input  logic [ENT_W-1:0]   dw_entry,
  input  logic               purge_en,
  input  logic [CHAIN_W-1:0] purge_slot
);
  localparam int DEPTH = 1 << CHAIN_W;

  logic [DEPTH-1:0] live_q;
  logic [TAG_W-1:0] tag_q [DEPTH];
  logic [ENT_W-1:0] ent_q [DEPTH];

  // Occupancy: later sources win (fill, then direct write, then purge)
  for (genvar s = 0; s < DEPTH; s++) begin : g_live
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        live_q[s] <= 1'b0;
      end else if (purge_en && purge_slot == CHAIN_W'(s)) begin
        live_q[s] <= 1'b0;
      end else if ((fill_en && fill_slot == CHAIN_W'(s)) ||
                   (dw_en && dw_slot == CHAIN_W'(s))) begin
        live_q[s] <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (fill_en) begin
      tag_q[fill_slot] <= fill_tag;
      ent_q[fill_slot] <= fill_entry;
    end
    if (dw_en) begin
      tag_q[dw_slot] <= dw_tag;
      ent_q[dw_slot] <= dw_entry;
    end
  end

  assign rd_live  = live_q[rd_slot];
  assign rd_tag   = tag_q[rd_slot];
  assign rd_entry = ent_q[rd_slot];
endmodule

// File: rtl/iotlb_walker.sv
module iotlb_walker
  import iotlb_pkg::*;
#(
  parameter int IOVA_W  = 28,
  parameter int CHAIN_W = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  tlb_mode_e                  mode,
  input  logic                       incl_on,
  input  logic [IOVA_W-1:0]          chain_mask,
  input  logic [CFG_W-1:0]           pdir_base,
  input  logic                       req_valid,
  output logic                       req_ready,
  input  logic [IOVA_W-1:0]          req_iova,
  output logic                       rsp_valid,
  input  logic                       rsp_ready,
  output logic [PA_W-1:0]            rsp_pa,
  output logic                       rsp_err,
  output logic                       mem_req_valid,
  input  logic                       mem_req_ready,
  output logic [CFG_W-1:0]           mem_req_addr,
  input  logic                       mem_rsp_valid,
  input  logic [ENT_W-1:0]           mem_rsp_data,
  output logic [CHAIN_W-1:0]         lk_slot,
  input  logic                       lk_live,
  input  logic [IOVA_W-PG_SHIFT-1:0] lk_tag,
  input  logic [ENT_W-1:0]           lk_entry,
  output logic                       fill_en,
  output logic [IOVA_W-PG_SHIFT-1:0] fill_tag,
  output logic [ENT_W-1:0]           fill_entry
);
  localparam int CHAIN_SHIFT = IOVA_W - CHAIN_W;
  localparam int TAG_W       = IOVA_W - PG_SHIFT;

  walk_st_e          st_q;
  logic [IOVA_W-1:0] iova_q;
  logic [PA_W-1:0]   pa_q;
  logic              err_q;
  logic [CFG_W-1:0]  maddr_q;

  logic [IOVA_W-1:0] iova_masked;
  logic [TAG_W-1:0]  page_idx;
  logic              virt_on;
  logic              lk_hit;
  logic              unused_walk_bits;

  assign iova_masked = iova_q & chain_mask;
  assign lk_slot     = iova_masked[CHAIN_SHIFT +: CHAIN_W];
  assign page_idx    = iova_q[IOVA_W-1:PG_SHIFT];
  assign virt_on     = (mode == TM_NORMAL) && incl_on;
  assign lk_hit      = lk_live && (lk_tag == page_idx) && lk_entry[E_VALID];
  assign unused_walk_bits = ^{iova_masked[CHAIN_SHIFT-1:0], pdir_base[2:0]};

  // Fill only from a fetched entry that is marked valid
  assign fill_en    = (st_q == W_FWAIT) && mem_rsp_valid && mem_rsp_data[E_VALID];
  assign fill_tag   = page_idx;
  assign fill_entry = mem_rsp_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= W_IDLE;
      iova_q  <= '0;
      pa_q    <= '0;
      err_q   <= 1'b0;
      maddr_q <= '0;
    end else begin
      case (st_q)
        W_IDLE: begin
          if (req_valid) begin
            iova_q <= req_iova;
            st_q   <= W_LOOK;
          end
        end
        W_LOOK: begin
          if (mode == TM_ERROR) begin
            pa_q  <= '0;
            err_q <= 1'b1;
            st_q  <= W_RESP;
          end else if (!virt_on) begin
            pa_q  <= PA_W'(iova_q);
            err_q <= 1'b0;
            st_q  <= W_RESP;
          end else if (lk_hit) begin
            pa_q  <= entry_to_pa(lk_entry, iova_q[PG_SHIFT-1:0]);
            err_q <= 1'b0;
            st_q  <= W_RESP;
          end else begin
            maddr_q <= {pdir_base[CFG_W-1:3], 3'b000} + (CFG_W'(page_idx) << 3);
            st_q    <= W_FREQ;
          end
        end
        W_FREQ: begin
          if (mem_req_ready) st_q <= W_FWAIT;
        end
        W_FWAIT: begin
          if (mem_rsp_valid) begin
            if (mem_rsp_data[E_VALID]) begin
              pa_q  <= entry_to_pa(mem_rsp_data, iova_q[PG_SHIFT-1:0]);
              err_q <= 1'b0;
            end else begin
              pa_q  <= '0;
              err_q <= 1'b1;
            end
            st_q <= W_RESP;
          end
        end
        W_RESP: begin
          if (rsp_ready) st_q <= W_IDLE;
        end
        default: st_q <= W_IDLE;
      endcase
    end
  end

  assign req_ready     = (st_q == W_IDLE);
  assign rsp_valid     = (st_q == W_RESP);
  assign rsp_pa        = pa_q;
  assign rsp_err       = err_q;
  assign mem_req_valid = (st_q == W_FREQ);
  assign mem_req_addr  = maddr_q;
endmodule

// File: rtl/iotlb_xlate.sv
module iotlb_xlate
  import iotlb_pkg::*;
#(
  parameter int IOVA_W  = 28,
  parameter int CHAIN_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [2:0]        cfg_sel,
  input  logic [CFG_W-1:0]  cfg_wdata,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [IOVA_W-1:0] req_iova,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [PA_W-1:0]   rsp_pa,
  output logic              rsp_err,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [CFG_W-1:0]  mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [ENT_W-1:0]  mem_rsp_data
);
  localparam int TAG_W = IOVA_W - PG_SHIFT;

  tlb_mode_e          mode;
  logic               incl_on;
  logic [CFG_W-1:0]   chain_mask;
  logic [CFG_W-1:0]   pdir_base;
  logic [ENT_W-1:0]   stage_entry;
  logic               purge_en;
  logic               dwrite_en;
  logic [CHAIN_W-1:0] cmd_slot;
  logic [TAG_W-1:0]   cmd_tag;

  logic [CHAIN_W-1:0] lk_slot;
  logic               lk_live;
  logic [TAG_W-1:0]   lk_tag;
  logic [ENT_W-1:0]   lk_entry;
  logic               fill_en;
  logic [TAG_W-1:0]   fill_tag;
  logic [ENT_W-1:0]   fill_entry;
  logic               unused_mask_hi;

  assign unused_mask_hi = ^chain_mask[CFG_W-1:IOVA_W];

  iotlb_cfg_regs #(.IOVA_W(IOVA_W), .CHAIN_W(CHAIN_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (cfg_we),
    .wr_sel     (cfg_sel),
    .wr_data    (cfg_wdata),
    .mode       (mode),
    .incl_on    (incl_on),
    .chain_mask (chain_mask),
    .pdir_base  (pdir_base),
    .stage_entry(stage_entry),
    .purge_en   (purge_en),
    .dwrite_en  (dwrite_en),
    .cmd_slot   (cmd_slot),
    .cmd_tag    (cmd_tag)
  );

  iotlb_entry_array #(.CHAIN_W(CHAIN_W), .TAG_W(TAG_W)) u_tlb (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_slot   (lk_slot),
    .rd_live   (lk_live),
    .rd_tag    (lk_tag),
    .rd_entry  (lk_entry),
    .fill_en   (fill_en),
    .fill_slot (lk_slot),
    .fill_tag  (fill_tag),
    .fill_entry(fill_entry),
    .dw_en     (dwrite_en),
    .dw_slot   (cmd_slot),
    .dw_tag    (cmd_tag),
    .dw_entry  (stage_entry),
    .purge_en  (purge_en),
    .purge_slot(cmd_slot)
  );

  iotlb_walker #(.IOVA_W(IOVA_W), .CHAIN_W(CHAIN_W)) u_walk (
    .clk          (clk),
    .rst_n        (rst_n),
    .mode         (mode),
    .incl_on      (incl_on),
    .chain_mask   (chain_mask[IOVA_W-1:0]),
    .pdir_base    (pdir_base),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .req_iova     (req_iova),
    .rsp_valid    (rsp_valid),
    .rsp_ready    (rsp_ready),
    .rsp_pa       (rsp_pa),
    .rsp_err      (rsp_err),
    .mem_req_valid(mem_req_valid),
    .mem_req_ready(mem_req_ready),
    .mem_req_addr (mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data (mem_rsp_data),
    .lk_slot      (lk_slot),
    .lk_live      (lk_live),
    .lk_tag       (lk_tag),
    .lk_entry     (lk_entry),
    .fill_en      (fill_en),
    .fill_tag     (fill_tag),
    .fill_entry   (fill_entry)
  );
endmodule

// File: rtl/iotlb_xlate_checker.sv
module iotlb_xlate_checker
  import iotlb_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [PA_W-1:0]   rsp_pa,
  input logic              rsp_err,
  input logic              mem_req_valid,
  input logic              mem_req_ready,
  input logic [CFG_W-1:0]  mem_req_addr
);
  // Directory reads since the last accepted request
  logic [1:0] fetch_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fetch_cnt <= '0;
    end else if (req_valid && req_ready) begin
      fetch_cnt <= '0;
    end else if (mem_req_valid && mem_req_ready && fetch_cnt != 2'b11) begin
      fetch_cnt <= fetch_cnt + 2'd1;
    end
  end

  assert_rsp_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_pa) && $stable(rsp_err)));

  assert_memreq_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

  assert_busy_noaccept_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid || mem_req_valid) |-> !req_ready);

  assert_err_zero_pa_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_err) |-> (rsp_pa == '0));

  assert_single_fetch_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && mem_req_ready) |-> (fetch_cnt == 2'd0));
endmodule

bind iotlb_xlate iotlb_xlate_checker u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_valid    (req_valid),
  .req_ready    (req_ready),
  .rsp_valid    (rsp_valid),
  .rsp_ready    (rsp_ready),
  .rsp_pa       (rsp_pa),
  .rsp_err      (rsp_err),
  .mem_req_valid(mem_req_valid),
  .mem_req_ready(mem_req_ready),
  .mem_req_addr (mem_req_addr)
);

// File: tb/test_iotlb_xlate.sv
`timescale 1ns/1ps
module test_iotlb_xlate;
  import iotlb_pkg::*;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              cfg_we = 1'b0;
  logic [2:0]        cfg_sel = '0;
  logic [31:0]       cfg_wdata = '0;
  logic              req_valid = 1'b0;
  logic              req_ready;
  logic [27:0]       req_iova = '0;
  logic              rsp_valid;
  logic              rsp_ready;
  logic [PA_W-1:0]   rsp_pa;
  logic              rsp_err;
  logic              mem_req_valid;
  logic              mem_req_ready;
  logic [31:0]       mem_req_addr;
  logic              mem_rsp_valid;
  logic [63:0]       mem_rsp_data;

  always #10 clk = ~clk;

  iotlb_xlate i_iotlb_xlate (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .req_valid(req_valid), .req_ready(req_ready), .req_iova(req_iova),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_pa(rsp_pa), .rsp_err(rsp_err),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data)
  );

  typedef struct {
    logic [PA_W-1:0] pa;
    logic            err;
    string           tag;
  } exp_t;

  exp_t        exp_q[$];
  int          n_chk = 0;
  int          n_fail = 0;
  int          fetch_cnt = 0;
  logic [31:0] last_faddr = '0;
  logic [31:0] pbase = '0;
  logic [63:0] pmem [logic [31:0]];
  int          stall_len = 0;
  int          stall_left = 0;

  task automatic check(input bit ok, input string r, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [2:0] sel, input logic [31:0] data);
    @(posedge clk); #1;
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
    @(posedge clk); #1;
    cfg_we = 1'b0;
  endtask

  // Driver: push the expectation, present the request, wait for completion
  task automatic send(input logic [27:0] iova, input logic [PA_W-1:0] pa, input logic err,
                      input int nfetch, input string r);
    int   f0;
    exp_t e;
    f0 = fetch_cnt;
    e.pa = pa; e.err = err; e.tag = r;
    exp_q.push_back(e);
    @(posedge clk); #1;
    req_valid = 1'b1; req_iova = iova;
    do @(negedge clk); while (!req_ready);
    @(posedge clk); #1;
    req_valid = 1'b0;
    while (exp_q.size() != 0) @(negedge clk);
    repeat (2) @(posedge clk);
    check(fetch_cnt - f0 == nfetch, {r, " directory read count"}, 64'(fetch_cnt - f0), 64'(nfetch));
    if (nfetch > 0)
      check(last_faddr == pbase + {4'h0, iova[27:12], 3'b000}, {r, " directory read address"},
            64'(last_faddr), 64'(pbase + {4'h0, iova[27:12], 3'b000}));
  endtask

  // Memory model: one stall cycle on each request, data two cycles later
  initial begin : mem_model
    logic [31:0] a;
    mem_req_ready = 1'b0; mem_rsp_valid = 1'b0; mem_rsp_data = '0;
    forever begin
      @(negedge clk);
      if (mem_req_valid) begin
        a = mem_req_addr;
        @(posedge clk); #1;
        mem_req_ready = 1'b1;
        @(posedge clk); #1;
        mem_req_ready = 1'b0;
        fetch_cnt++;
        last_faddr = a;
        mem_rsp_data = pmem.exists(a) ? pmem[a] : 64'h0;
        mem_rsp_valid = 1'b1;
        @(posedge clk); #1;
        mem_rsp_valid = 1'b0;
      end
    end
  end

  // Monitor: applies response back-pressure, pops and compares
  initial begin : monitor
    exp_t e;
    rsp_ready = 1'b0;
    forever begin
      @(negedge clk);
      if (rsp_valid) begin
        check(req_ready == 1'b0, "R10 request port closed while response pending", 64'(req_ready), 64'd0);
        if (rsp_ready) begin
          if (exp_q.size() == 0) begin
            check(1'b0, "R10 unexpected response", 64'(rsp_pa), 64'd0);
          end else begin
            e = exp_q.pop_front();
            check(rsp_pa == e.pa, {e.tag, " translated address"}, 64'(rsp_pa), 64'(e.pa));
            check(rsp_err == e.err, {e.tag, " error flag"}, 64'(rsp_err), 64'(e.err));
          end
          @(posedge clk); #1;
          rsp_ready = 1'b0;
          stall_left = stall_len;
        end else if (stall_left > 0) begin
          stall_left--;
        end else begin
          @(posedge clk); #1;
          rsp_ready = 1'b1;
        end
      end
    end
  end

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL R10 watchdog expired actual=hung expected=complete");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  localparam logic [31:0] BASE = 32'h0010_0000;

  initial begin : stimulus
    pmem[BASE + 32'h91A0]  = 64'hA000_1234_5678_9047; // page 0x1234, valid
    pmem[BASE + 32'h1000]  = 64'h0000_0000_0555_5000; // page 0x0200, not valid
    pmem[BASE + 32'h94C8]  = 64'h0000_0000_0077_7001; // page 0x1299, valid
    pmem[BASE + 32'h1A2B0] = 64'h0000_0000_0011_1001; // page 0x3456, valid

    repeat (3) @(posedge clk);
    @(negedge clk);
    check(req_ready == 1'b1, "R1 reset request ready", 64'(req_ready), 64'd1);
    check(rsp_valid == 1'b0, "R1 reset no response", 64'(rsp_valid), 64'd0);
    check(mem_req_valid == 1'b0, "R1 reset no memory read", 64'(mem_req_valid), 64'd0);
    rst_n = 1'b1;

    send(28'h0ABC123, 52'h0ABC123, 1'b0, 0, "R1 pass-through after reset");

    cfg_write(3'd3, BASE); pbase = BASE;
    cfg_write(3'd0, 32'h0002_0080);

    send(28'h1234567, 52'hA123456789567, 1'b0, 1, "R3 miss fetch");
    send(28'h1234ABC, 52'hA123456789ABC, 1'b0, 0, "R4 hit same page");

    stall_len = 3;
    send(28'h0200010, 52'h0, 1'b1, 1, "R5 invalid entry error");
    send(28'h0200010, 52'h0, 1'b1, 1, "R5 invalid entry not kept");
    stall_len = 0;

    send(28'h1299ABC, 52'h0000000777ABC, 1'b0, 1, "R6 conflicting page replaces slot");
    send(28'h1234567, 52'hA123456789567, 1'b0, 1, "R6 evicted page refetched");

    cfg_write(3'd2, 32'h00F0_0000);
    send(28'h1234567, 52'hA123456789567, 1'b0, 1, "R6 narrowed mask picks other slot");
    cfg_write(3'd2, 32'h0FF0_0000);
    send(28'h1234567, 52'hA123456789567, 1'b0, 0, "R6 default mask slot still filled");

    cfg_write(3'd4, 32'h5000_00AB);
    cfg_write(3'd5, 32'hCDEF_1001);
    cfg_write(3'd1, 32'h0345_6023);
    send(28'h3456FFF, 52'h500ABCDEF1FFF, 1'b0, 0, "R7 direct write hit");

    cfg_write(3'd1, 32'h0345_6022);
    cfg_write(3'd6, 32'h0345_6021);
    send(28'h3456FFF, 52'h500ABCDEF1FFF, 1'b0, 0, "R11 other code and select ignored");

    cfg_write(3'd1, 32'h0340_0021);
    send(28'h3456FFF, 52'h0000000111FFF, 1'b0, 1, "R8 purged slot refetched");

    cfg_write(3'd1, 32'h0770_0021);
    send(28'h3456FFF, 52'h0000000111FFF, 1'b0, 0, "R8 purge of empty slot harmless");

    cfg_write(3'd0, 32'h0001_0080);
    stall_len = 2;
    send(28'h1234567, 52'h0, 1'b1, 0, "R9 error mode");
    stall_len = 0;

    cfg_write(3'd0, 32'h0000_0080);
    send(28'hFFFFFFF, 52'h000000FFFFFFF, 1'b0, 0, "R2 real mode pass-through");

    cfg_write(3'd0, 32'h0002_0000);
    send(28'h1234567, 52'h0000001234567, 1'b0, 0, "R2 include field clear passes through");

    @(posedge clk); #1; rst_n = 1'b0;
    repeat (2) @(posedge clk); #1; rst_n = 1'b1;
    send(28'h1234567, 52'h0000001234567, 1'b0, 0, "R1 real mode after second reset");
    cfg_write(3'd3, BASE);
    cfg_write(3'd0, 32'h0002_0080);
    send(28'h1234567, 52'hA123456789567, 1'b0, 1, "R1 table emptied by reset");

    repeat (4) @(posedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule